// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits behind a serial memory front end and gathers the data bytes of one array write command into a page-sized staging buffer. A command opens with a start address and the state of the write-enable latch. Data bytes then arrive one at a time. Each byte lands at the current in-page offset, and that offset advances and wraps inside the page, so the page base never changes. A 16-bit mask records which page locations have received a byte.

Nothing reaches the array while bytes are arriving. When chip select rises, the front end reports the frame end together with a flag that says whether the frame closed on a whole byte. If the frame is accepted, the block starts a self-timed write cycle. During this cycle the busy flag is high, every received location that is not protected is written to the array in ascending slot order, and a one-cycle pulse on the last busy cycle tells the status logic to clear its write-enable latch. The cycle length is a parameter counted in system clocks.

Top module: `page_write_buffer`

## Requirements
- R1: While reset is held and just after it is released, `busy`, `mem_we` and `wel_clear` are low.
- R2: Every array write produced by a command goes to an address whose upper bits (all bits above bit 3) equal those of the command's start address. Its low four bits are the page slot.
- R3: The first data byte goes to slot `cmd_addr[3:0]`, and each later byte goes to the next slot. After slot 15 the next byte goes to slot 0 of the same page.
- R4: When more than 16 bytes arrive in one command, each slot holds the byte most recently received for it.
- R5: Only slots that received a byte are written, and they are written in ascending slot order. All other locations in the page are left alone.
- R6: The array is not written before the frame end. A frame is dropped, with no write and no busy cycle, when `frame_ok` is low at frame end or when no byte was received.
- R7: A frame is dropped, with no write and no busy cycle, when `cmd_wel` was low at the command start.
- R8: A slot whose address has `wr_prot` high while it is presented on `mem_addr` is not written. The other received slots are still written.
- R9: `busy` rises in the cycle after an accepted frame end and stays high for exactly `CYCLE_CLKS` cycles.
- R10: `wel_clear` pulses for exactly one cycle, and that cycle is the last cycle in which `busy` is high.
- R11: Command starts, data bytes and frame ends that arrive while `busy` is high are ignored. They cause no write and no further busy cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | One-cycle strobe that opens an array write command |
| cmd_addr | input | ADDR_W | Start address of the command |
| cmd_wel | input | 1 | Write-enable latch state, sampled at the command start |
| byte_valid | input | 1 | One-cycle strobe for a received data byte |
| byte_data | input | 8 | Received data byte |
| frame_end | input | 1 | One-cycle strobe when chip select rises |
| frame_ok | input | 1 | High when the frame ended on a whole byte |
| wr_prot | input | 1 | Protection flag for the address currently on mem_addr |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | High for the whole self-timed write cycle |
| wel_clear | output | 1 | One-cycle pulse at the end of the write cycle that clears the write-enable latch |

## Verification
The block is driven with the following commands:
- an aligned full page, which shows slot order and base address;
- a short burst that starts two bytes before the page end, which can only pass if the offset wraps and the commit still walks slots in ascending order;
- a twenty-byte burst, which separates "last byte wins" from "first byte wins";
- a page whose upper half is protected, which shows that writes are skipped per slot rather than the whole commit being dropped.

Frames with the latch clear, frames with a broken last byte and empty frames must all produce neither writes nor busy. A second full command sent during a write cycle must leave no trace.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_BUSY    = 2'd2
    } pwb_state_t;

    // Number of bits needed to count 0..n inclusive.
    function automatic int cnt_bits(input int n);
        int w;
        w = 1;
        while ((1 << w) <= n) w++;
        return w;
    endfunction

endpackage

// File: rtl/pwb_collector.sv
module pwb_collector
    import pwb_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int PAGE_BYTES = 16
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           load,
    input  logic [ADDR_W-1:0]              load_addr,
    input  logic                           accept,
    input  byte_t                          din,
    input  logic [$clog2(PAGE_BYTES)-1:0]  rd_slot,
    output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page,
    output logic [PAGE_BYTES-1:0]          mask,
    output byte_t                          rd_data
);
    localparam int SLOT_W = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - SLOT_W;
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(PAGE_BYTES - 1);

    logic [PAGE_W-1:0]     page_q;
    logic [SLOT_W-1:0]     offset_q;
    logic [PAGE_BYTES-1:0] mask_q;
    byte_t                 slots_w [PAGE_BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q   <= '0;
            offset_q <= '0;
            mask_q   <= '0;
        end else if (load) begin
            page_q   <= load_addr[ADDR_W-1:SLOT_W];
            offset_q <= load_addr[SLOT_W-1:0];
            mask_q   <= '0;
        end else if (accept) begin
            mask_q[offset_q] <= 1'b1;
            offset_q         <= offset_q + 1'b1;
        end
    end

    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
        byte_t slot_q;
        always_ff @(posedge clk) begin
            if (accept && !load && offset_q == SLOT_W'(i))
                slot_q <= din;
        end
        assign slots_w[i] = slot_q;
    end

    assign page    = page_q;
    assign mask    = mask_q;
    assign rd_data = slots_w[rd_slot];

    // R5
    mask_mark_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !load) |=> mask_q[$past(offset_q)]);

    // R3
    offset_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !load && offset_q == LAST_SLOT) |=> (offset_q == '0));

endmodule

// File: rtl/pwb_sequencer.sv
module pwb_sequencer
    import pwb_pkg::*;
#(
    parameter int PAGE_BYTES = 16,
    parameter int CYCLE_CLKS = 250000
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cmd_start,
    input  logic                          cmd_wel,
    input  logic                          byte_valid,
    input  logic                          frame_end,
    input  logic                          frame_ok,
    input  logic [PAGE_BYTES-1:0]         mask,
    output logic                          load,
    output logic                          accept,
    output logic [$clog2(PAGE_BYTES)-1:0] slot,
    output logic                          slot_sel,
    output logic                          busy,
    output logic                          done
);
    localparam int SLOT_W = $clog2(PAGE_BYTES);
    localparam int CNT_W  = cnt_bits(CYCLE_CLKS);
    localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(CYCLE_CLKS - 1);
    localparam logic [CNT_W-1:0] PAGE_CNT  = CNT_W'(PAGE_BYTES);

    pwb_state_t       state_q, state_d;
    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;
    logic             commit;

    assign busy   = (state_q == ST_BUSY);
    assign load   = cmd_start && !busy;
    assign accept = byte_valid && !cmd_start && (state_q == ST_COLLECT);
    assign commit = (state_q == ST_COLLECT) && frame_end && frame_ok
                    && armed_q && (|mask);
    assign done   = busy && (cnt_q == LAST_CNT);

    assign slot     = cnt_q[SLOT_W-1:0];
    assign slot_sel = busy && (cnt_q < PAGE_CNT) && mask[slot];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_start) state_d = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (cmd_start)      state_d = ST_COLLECT;
                else if (commit)    state_d = ST_BUSY;
                else if (frame_end) state_d = ST_IDLE;
            end
            ST_BUSY: begin
                if (done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load) armed_q <= cmd_wel;
            if (busy) cnt_q <= cnt_q + 1'b1;
            else      cnt_q <= '0;
        end
    end

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    // R10
    done_end_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R6
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(frame_end && frame_ok));

    // R7
    busy_armed_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(armed_q));

endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer
    import pwb_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int PAGE_BYTES = 16,
    parameter int CYCLE_CLKS = 250000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_wel,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              frame_end,
    input  logic              frame_ok,
    input  logic              wr_prot,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              busy,
    output logic              wel_clear
);
    localparam int SLOT_W = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - SLOT_W;

    logic                  load, accept, slot_sel;
    logic [SLOT_W-1:0]     slot;
    logic [PAGE_W-1:0]     page;
    logic [PAGE_BYTES-1:0] mask;
    byte_t                 rd_data;

    pwb_sequencer #(
        .PAGE_BYTES (PAGE_BYTES),
        .CYCLE_CLKS (CYCLE_CLKS)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cmd_start  (cmd_start),
        .cmd_wel    (cmd_wel),
        .byte_valid (byte_valid),
        .frame_end  (frame_end),
        .frame_ok   (frame_ok),
        .mask       (mask),
        .load       (load),
        .accept     (accept),
        .slot       (slot),
        .slot_sel   (slot_sel),
        .busy       (busy),
        .done       (wel_clear)
    );

    pwb_collector #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_col (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_addr (cmd_addr),
        .accept    (accept),
        .din       (byte_data),
        .rd_slot   (slot),
        .page      (page),
        .mask      (mask),
        .rd_data   (rd_data)
    );

    assign mem_addr  = {page, slot};
    assign mem_wdata = rd_data;
    assign mem_we    = slot_sel && !wr_prot;

    // R11
    page_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(page));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !mem_we && !wel_clear));

endmodule

// File: tb/sim_page_write_buffer.sv
module sim_page_write_buffer;
    localparam int ADDR_W = 11;
    localparam int CYC    = 40;

    typedef struct { int addr; int data; } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_start = 0, cmd_wel = 0, byte_valid = 0, frame_end = 0, frame_ok = 0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [7:0] byte_data = '0;
    logic wr_prot;
    logic mem_we, busy, wel_clear;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0] mem_wdata;
    int prot_lo = 'h800;

    always #2 clk = ~clk;

    assign wr_prot = (int'(mem_addr) >= prot_lo);

    page_write_buffer #(.ADDR_W(ADDR_W), .PAGE_BYTES(16), .CYCLE_CLKS(CYC)) u0 (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
        .cmd_wel(cmd_wel), .byte_valid(byte_valid), .byte_data(byte_data),
        .frame_end(frame_end), .frame_ok(frame_ok), .wr_prot(wr_prot),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .busy(busy), .wel_clear(wel_clear)
    );

    int errors = 0, checks = 0;
    exp_t q[$];
    int exp_eps = 0, got_eps = 0;

    int m_page, m_off, m_buf[16];
    bit [15:0] m_mask;
    bit m_wel;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Driver tasks: entered and left on a falling edge.
    task automatic cmd(input int a, input bit wel, input bit model);
        cmd_start = 1; cmd_addr = ADDR_W'(a); cmd_wel = wel;
        @(negedge clk);
        cmd_start = 0;
        if (model) begin
            m_page = a >> 4; m_off = a & 15; m_mask = '0; m_wel = wel;
        end
    endtask

    task automatic send(input int d, input bit model);
        byte_valid = 1; byte_data = 8'(d);
        @(negedge clk);
        byte_valid = 0;
        if (model) begin
            m_buf[m_off] = d & 255; m_mask[m_off] = 1'b1; m_off = (m_off + 1) % 16;
        end
    endtask

    task automatic fin(input bit ok, input bit model);
        frame_end = 1; frame_ok = ok;
        @(negedge clk);
        frame_end = 0; frame_ok = 0;
        if (model && ok && m_wel && m_mask != 0) begin
            for (int i = 0; i < 16; i++) begin
                int a;
                a = (m_page << 4) | i;
                if (m_mask[i] && !(a >= prot_lo)) q.push_back('{a, m_buf[i]});
            end
            exp_eps++;
        end
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: pops expected writes and measures each busy episode.
    bit prev_busy = 0, prev_done = 0;
    int busy_len = 0, done_cnt = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_we) begin
                if (q.size() == 0) begin
                    chk(0, "R6", "unexpected array write addr", int'(mem_addr), -1);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(int'(mem_addr) == e.addr, "R2 R3 R5 R8", "write address",
                        int'(mem_addr), e.addr);
                    chk(int'(mem_wdata) == e.data, "R4", "write data",
                        int'(mem_wdata), e.data);
                end
            end
            if (busy) begin
                busy_len++;
                if (wel_clear) done_cnt++;
            end
            if (!busy && prev_busy) begin
                chk(busy_len == CYC, "R9", "busy length", busy_len, CYC);
                chk(done_cnt == 1 && prev_done, "R10", "wel_clear pulses", done_cnt, 1);
                got_eps++;
                busy_len = 0; done_cnt = 0;
            end
            prev_busy = busy;
            prev_done = wel_clear;
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++; checks++;
            $display("FAIL R9 watchdog: cycles=%0d expected below %0d", cyc, 100000);
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !mem_we && !wel_clear, "R1", "outputs in reset",
            {busy, mem_we, wel_clear}, 0);
        rst = 0;
        @(negedge clk);
        chk(!busy && !mem_we && !wel_clear, "R1", "outputs after reset",
            {busy, mem_we, wel_clear}, 0);

        // Aligned full page.
        cmd('h020, 1, 1);
        for (int i = 0; i < 16; i++) send(i * 3 + 1, 1);
        chk(!busy && !mem_we, "R6", "quiet before frame end", {busy, mem_we}, 0);
        fin(1, 1);
        wait_idle();

        // Partial burst wrapping past the page end.
        cmd('h03E, 1, 1);
        for (int i = 0; i < 4; i++) send('hA0 + i, 1);
        fin(1, 1);
        wait_idle();

        // Over-long burst: last byte for each slot wins.
        cmd('h045, 1, 1);
        for (int i = 0; i < 20; i++) send('h10 + i, 1);
        fin(1, 1);
        wait_idle();

        // Latch clear at command: dropped.
        cmd('h100, 0, 1);
        for (int i = 0; i < 3; i++) send('h55, 1);
        fin(1, 1);
        repeat (4) @(negedge clk);
        chk(!busy, "R7", "busy after frame with latch clear", busy, 0);

        // Broken last byte: dropped.
        cmd('h140, 1, 1);
        for (int i = 0; i < 3; i++) send('h66, 1);
        fin(0, 1);
        repeat (4) @(negedge clk);
        chk(!busy, "R6", "busy after broken frame", busy, 0);

        // Empty frame: dropped.
        cmd('h180, 1, 1);
        fin(1, 1);
        repeat (4) @(negedge clk);
        chk(!busy, "R6", "busy after empty frame", busy, 0);

        // Upper half of the last page protected.
        prot_lo = 'h7F8;
        cmd('h7F0, 1, 1);
        for (int i = 0; i < 16; i++) send('hC0 + i, 1);
        fin(1, 1);
        wait_idle();
        prot_lo = 'h800;

        // Traffic during a write cycle is ignored.
        cmd('h055, 1, 1);
        send('h21, 1); send('h22, 1);
        fin(1, 1);
        chk(busy, "R11", "busy at start of cycle", busy, 1);
        cmd('h200, 1, 0);
        for (int i = 0; i < 3; i++) send('h77, 0);
        fin(1, 0);
        wait_idle();
        repeat (CYC + 5) @(negedge clk);
        chk(!busy, "R11", "busy after ignored command", busy, 0);

        chk(q.size() == 0, "R5", "writes still expected", q.size(), 0);
        chk(got_eps == exp_eps, "R9", "busy episodes", got_eps, exp_eps);
        report();
    end
endmodule